// File: doc/BRIEF.md
# Two-Approach Intersection Light Controller

This block drives the lamps of two traffic lights that share one crossing. Each light runs its own four-phase sequencer: red, a short yellow before green, green, and a longer yellow after green, then back to red. A single three-state arbiter acts as a monitor between the two sequencers. It hands the right to leave red to one light at a time, so the crossing can never show a non-red aspect on both approaches at once.

All phase durations are counted in pulses of a one-per-second time-base strobe, `sec_tick`, which is one clock wide. Each approach has a vehicle sensor. Both sensors pass through a two-flop synchroniser before any logic uses them. The whole block is fully synchronous, so which states can be reached does not depend on any ordering between the two lights.

Top module: `tlc_pair_top`

## Requirements
- R1: After reset, both lamp outputs show red (`4'b0001`), `arb_state` is 0, and both red-dwell counters are cleared, so neither light can leave red before it has seen 5 ticks.
- R2: Each lamp output is one-hot. Bit 0 is red, bit 1 is the yellow before green, bit 2 is green and bit 3 is the yellow after green. A light moves only red → yellow-before → green → yellow-after → red.
- R3: The yellow before green lasts exactly 2 ticks. With a tick in every cycle, it is shown for 2 cycles.
- R4: Green lasts exactly 20 ticks.
- R5: The yellow after green lasts exactly 5 ticks.
- R6: A light requests to leave red only when all of the following hold:
  - its red-dwell counter has reached 5 ticks (the counter saturates at 5 and restarts from 0 each time the light re-enters red);
  - its synchronised sensor is active.

  The light leaves red on the cycle after the arbiter grants it. With a tick in every cycle and its sensor held high, red therefore lasts 7 cycles.
- R7: The arbiter, when idle, grants approach A whenever A requests. It grants approach B only when B requests and A's synchronised sensor is inactive. A simultaneous request goes to A.
- R8: `arb_state` encodes 0 = idle, 1 = A owns the crossing, 2 = B owns it, and never shows 3. A request moves the arbiter out of idle on the next clock. The owner's final yellow tick returns the arbiter to idle on the same edge at which that light turns red.
- R9: No cycle ever shows both lamps non-red.
- R10: Each sensor passes through two flip-flops. A sensor raised between clock edges on a saturated, idle crossing gives `arb_state` = owner after 3 edges and the yellow lamp after 4 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle time-base strobe, one per second |
| approach_a | input | 1 | Vehicle sensor of approach A, asynchronous |
| approach_b | input | 1 | Vehicle sensor of approach B, asynchronous |
| lamp_a | output | 4 | One-hot lamp state of light A |
| lamp_b | output | 4 | One-hot lamp state of light B |
| arb_state | output | 2 | Arbiter state: 0 idle, 1 A owns, 2 B owns |

## Verification
Two functions can fall in the same cycle. The first is the owner's final yellow tick, which releases the arbiter. The second is a waiting request from the other light, which must not be granted on that same edge; it may be granted only on the following edge.

A directed case provokes this. Approach A cycles while B waits with its dwell saturated and its sensor high. The bench then expects `arb_state` 0 at the sample where A turns red, 2 on the next sample, and B's yellow one sample later.

Long random runs with sparse ticks and toggling sensors also make a release and a fresh request coincide many times. There, each cycle is compared against a reference model written from the requirements, and the bench checks that both lamps are never non-red together.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        PH_RED    = 2'd0,
        PH_AMB_UP = 2'd1,
        PH_GO     = 2'd2,
        PH_AMB_DN = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ARB_FREE  = 2'd0,
        ARB_OWN_A = 2'd1,
        ARB_OWN_B = 2'd2
    } arb_e;

    localparam int NUM_APPROACH = 2;
    localparam int LAMP_W       = 4;

endpackage

// File: rtl/tlc_sync.sv
module tlc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/tlc_light.sv
module tlc_light
    import tlc_pkg::*;
#(
    parameter int RED_MIN_T = 5,
    parameter int Y1_T      = 2,
    parameter int GRN_T     = 20,
    parameter int Y2_T      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              sense_i,
    input  logic              grant_i,
    output logic [LAMP_W-1:0] lamp_o,
    output logic              req_o,
    output logic              rel_o
);
    localparam int MAX_AB = (RED_MIN_T > Y1_T) ? RED_MIN_T : Y1_T;
    localparam int MAX_CD = (GRN_T > Y2_T) ? GRN_T : Y2_T;
    localparam int MAXT   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXT + 1);
    localparam logic [CW-1:0] RED_END = CW'(RED_MIN_T);
    localparam logic [CW-1:0] Y1_END  = CW'(Y1_T - 1);
    localparam logic [CW-1:0] GRN_END = CW'(GRN_T - 1);
    localparam logic [CW-1:0] Y2_END  = CW'(Y2_T - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } light_t;

    localparam light_t RST = '{ph: PH_RED, cnt: '0};

    light_t d, q;

    always_comb begin
        d     = q;
        req_o = 1'b0;
        rel_o = 1'b0;
        case (q.ph)
            PH_RED: begin
                req_o = sense_i && (q.cnt == RED_END);
                if (grant_i) begin
                    d.ph  = PH_AMB_UP;
                    d.cnt = '0;
                end else if (tick_i && (q.cnt != RED_END)) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_AMB_UP: begin
                if (tick_i) begin
                    if (q.cnt == Y1_END) begin
                        d.ph  = PH_GO;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_GO: begin
                if (tick_i) begin
                    if (q.cnt == GRN_END) begin
                        d.ph  = PH_AMB_DN;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_AMB_DN: begin
                if (tick_i) begin
                    if (q.cnt == Y2_END) begin
                        rel_o = 1'b1;
                        d.ph  = PH_RED;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign lamp_o = LAMP_W'(1) << q.ph;

    AST_LAMP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lamp_o)); // R2
    AST_ORDER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_o == 4'b0010) |=> (lamp_o == 4'b0010 || lamp_o == 4'b0100)); // R2
    AST_TIMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!lamp_o[0] && !tick_i) |=> $stable(lamp_o)); // R3
    AST_RED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_o[0] && !grant_i) |=> lamp_o[0]); // R6
endmodule

// File: rtl/tlc_arbiter.sv
module tlc_arbiter
    import tlc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  logic req_b,
    input  logic sense_a,
    input  logic rel_a,
    input  logic rel_b,
    output arb_e state_o
);
    arb_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ARB_FREE: begin
                if (req_a)                 st_d = ARB_OWN_A;
                else if (req_b && !sense_a) st_d = ARB_OWN_B;
            end
            ARB_OWN_A: if (rel_a) st_d = ARB_FREE;
            ARB_OWN_B: if (rel_b) st_d = ARB_FREE;
            default:   st_d = ARB_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARB_FREE;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    AST_ARB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 2'd3); // R8
    AST_ARB_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ARB_OWN_A && !rel_a) |=> st_q == ARB_OWN_A); // R8
    AST_ARB_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ARB_FREE && req_a) |=> st_q == ARB_OWN_A); // R7
endmodule

// File: rtl/tlc_pair_top.sv
module tlc_pair_top
    import tlc_pkg::*;
#(
    parameter int RED_MIN_T   = 5,
    parameter int Y1_T        = 2,
    parameter int GRN_T       = 20,
    parameter int Y2_T        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       approach_a,
    input  logic       approach_b,
    output logic [3:0] lamp_a,
    output logic [3:0] lamp_b,
    output logic [1:0] arb_state
);
    logic [NUM_APPROACH-1:0] sense_raw, sense_s, req, rel, grant;
    logic [LAMP_W-1:0]       lamp [NUM_APPROACH];
    arb_e                    arb;

    assign sense_raw = {approach_b, approach_a};

    tlc_sync #(.W(NUM_APPROACH), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sense_raw),
        .dout (sense_s)
    );

    assign grant[0] = (arb == ARB_OWN_A);
    assign grant[1] = (arb == ARB_OWN_B);

    for (genvar g = 0; g < NUM_APPROACH; g++) begin : g_light
        tlc_light #(
            .RED_MIN_T(RED_MIN_T),
            .Y1_T     (Y1_T),
            .GRN_T    (GRN_T),
            .Y2_T     (Y2_T)
        ) u_light (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (sec_tick),
            .sense_i(sense_s[g]),
            .grant_i(grant[g]),
            .lamp_o (lamp[g]),
            .req_o  (req[g]),
            .rel_o  (rel[g])
        );
    end

    tlc_arbiter u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_a  (req[0]),
        .req_b  (req[1]),
        .sense_a(sense_s[0]),
        .rel_a  (rel[0]),
        .rel_b  (rel[1]),
        .state_o(arb)
    );

    assign lamp_a    = lamp[0];
    assign lamp_b    = lamp[1];
    assign arb_state = arb;

    AST_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
        lamp_a[0] || lamp_b[0]); // R9
    AST_B_OWNER_A_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_state == 2'd2) |-> lamp_a[0]); // R7
endmodule

// File: tb/tlc_pair_top_tb.sv
`timescale 1ns/1ps
module tlc_pair_top_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sec_tick;
    logic       approach_a, approach_b;
    logic [3:0] lamp_a, lamp_b;
    logic [1:0] arb_state;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 1'b0;

    // reference model state
    int mph  [2];
    int mcnt [2];
    int marb;
    bit ms1 [2];
    bit ms2 [2];

    always #4 clk = ~clk;

    tlc_pair_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .approach_a(approach_a),
        .approach_b(approach_b),
        .lamp_a    (lamp_a),
        .lamp_b    (lamp_b),
        .arb_state (arb_state)
    );

    function automatic int dur(int ph);
        case (ph)
            1:       return 2;
            2:       return 20;
            default: return 5;
        endcase
    endfunction

    function automatic logic [3:0] exp_lamp(int ph);
        return 4'b0001 << ph;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model built from the requirements
    always @(posedge clk) begin
        bit req [2];
        bit rel [2];
        int narb;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                mph[i] = 0; mcnt[i] = 0; ms1[i] = 0; ms2[i] = 0;
            end
            marb = 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                req[i] = (mph[i] == 0) && (mcnt[i] == 5) && ms2[i];
                rel[i] = (mph[i] == 3) && sec_tick && (mcnt[i] == dur(3) - 1);
            end
            narb = marb;
            if (marb == 0) begin
                if (req[0])              narb = 1;
                else if (req[1] && !ms2[0]) narb = 2;
            end else if (marb == 1 && rel[0]) narb = 0;
            else if (marb == 2 && rel[1]) narb = 0;
            for (int i = 0; i < 2; i++) begin
                if (mph[i] == 0) begin
                    if (marb == i + 1) begin mph[i] = 1; mcnt[i] = 0; end
                    else if (sec_tick && mcnt[i] < 5) mcnt[i]++;
                end else if (sec_tick) begin
                    if (mcnt[i] == dur(mph[i]) - 1) begin
                        mph[i] = (mph[i] + 1) % 4; mcnt[i] = 0;
                    end else mcnt[i]++;
                end
            end
            ms2[0] = ms1[0]; ms2[1] = ms1[1];
            ms1[0] = approach_a; ms1[1] = approach_b;
            marb = narb;
        end
    end

    task automatic run_len_a(logic [3:0] code, output int n);
        n = 0;
        while (lamp_a === code && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        void'($urandom(32'h5EED_0C0A));
        rst_n = 1'b0; sec_tick = 1'b1; approach_a = 1'b0; approach_b = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 lamp_a reset", lamp_a, 4'b0001);
        chk("R1 lamp_b reset", lamp_b, 4'b0001);
        chk("R1 arb reset", arb_state, 2'd0);
        repeat (8) @(negedge clk);
        chk("R6 no sensor stays red A", lamp_a, 4'b0001);
        chk("R6 no sensor stays red B", lamp_b, 4'b0001);
        chk("R8 idle without request", arb_state, 2'd0);

        approach_a = 1'b1; approach_b = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 red after 3 edges", lamp_a, 4'b0001);
        chk("R8 A owns after request", arb_state, 2'd1);
        @(negedge clk);
        chk("R10 yellow after 4 edges", lamp_a, 4'b0010);
        chk("R7 B held red on tie", lamp_b, 4'b0001);

        run_len_a(4'b0010, n); chk("R3 yellow-before length", n, 2);
        chk("R2 green follows", lamp_a, 4'b0100);
        run_len_a(4'b0100, n); chk("R4 green length", n, 20);
        chk("R2 yellow-after follows", lamp_a, 4'b1000);
        run_len_a(4'b1000, n); chk("R5 yellow-after length", n, 5);
        chk("R2 red follows", lamp_a, 4'b0001);
        chk("R8 release on red", arb_state, 2'd0);
        chk("R7 B blocked by A sensor", lamp_b, 4'b0001);
        run_len_a(4'b0001, n); chk("R6 red dwell length", n, 7);
        chk("R7 A again wins", lamp_b, 4'b0001);

        approach_a = 1'b0;
        n = 0;
        while (lamp_a !== 4'b0001 && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R8 idle at release", arb_state, 2'd0);
        chk("R9 B still red at release", lamp_b, 4'b0001);
        @(negedge clk);
        chk("R8 B granted next edge", arb_state, 2'd2);
        chk("R9 B still red on grant", lamp_b, 4'b0001);
        @(negedge clk);
        chk("R7 B leaves red", lamp_b, 4'b0010);
        chk("R9 A red while B runs", lamp_a, 4'b0001);

        // random phase against the reference model
        rst_n = 1'b0; approach_a = 1'b0; approach_b = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        for (int c = 0; c < 30000; c++) begin
            @(negedge clk);
            chk("R2 lamp_a model", lamp_a, exp_lamp(mph[0]));
            chk("R2 lamp_b model", lamp_b, exp_lamp(mph[1]));
            chk("R8 arb model", arb_state, marb);
            chk("R9 mutex", (lamp_a[0] | lamp_b[0]), 1'b1);
            sec_tick = ($urandom % 3) == 0;
            if (($urandom % 24) == 0) approach_a = ~approach_a;
            if (($urandom % 24) == 0) approach_b = ~approach_b;
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule